// File: doc/BRIEF.md
# Fractional-N Feedback Divide Sequencer

This block supplies the divide value that a fractional-N synthesizer's feedback counter uses on each of its cycles. It takes an integer divide word and a fraction word. A chain of first-order accumulators, arranged as a cascaded noise-shaping modulator, turns the fraction into a stream of small integer corrections. Each correction is added to the integer word. Over a long run, the mean of the emitted divide values equals the integer word plus (fraction + 0.5) / 2^FRAC_W. The extra half step comes from a least significant bit that is always set at the bottom of the accumulator input. With the default two-stage shaping, the quantization error of the stream is pushed towards high offset frequencies, where the synthesizer loop filters it out.

An integer-only input bypasses the modulator. When it is set, every emitted value is the integer word and every accumulator is held at zero. This costs frequency resolution and gives an output free of modulation. The block produces one new value on every clock edge, and that value is built from the inputs seen at that single edge. A new integer and fraction pair therefore always takes effect complete, never half applied. The counter that performs the division, the phase detector, the loop filter and the oscillator lie outside this block.

Top module: `frac_div_modulator`

## Requirements
- R1: While rst_n is low, div_value is 0 and div_valid is 0.
- R2: div_valid goes to 1 on the first rising clock edge after rst_n is released, and then stays at 1 until the next reset.
- R3: When int_only is 1 at a rising edge, the div_value registered at that edge equals int_word. The upper bit of div_value is then 0.
- R4: In fractional mode (int_only = 0) with int_word of at least 1, every div_value lies between int_word - 1 and int_word + 2, inclusive, for the two-stage variant (ORDER = 2).
- R5: Start from reset with a constant fraction m and a constant integer word I, and take the first 2^(FRAC_W+1) values. For ORDER = 1 their sum is exactly I*2^(FRAC_W+1) + 2m + 1. For ORDER = 2 the sum is that value or one more.
- R6: The first value emitted from cleared state equals int_word. Cleared state is reached after reset, or after any edge at which int_only was 1.
- R7: With frac_word all ones and ORDER = 2, the second value emitted from cleared state equals int_word + 2.
- R8: A change of int_word appears in full in div_value at the first rising edge that samples the new value, one register stage later.
- R9: The parameters are checked when the design is built: INT_W of at least 2, FRAC_W of at least 1, and ORDER of 1 or 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Feedback divider clock; one value per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_word | input | INT_W (7) | Integer part of the divide ratio |
| frac_word | input | FRAC_W (18) | Fractional part of the divide ratio, in units of 2^-FRAC_W |
| int_only | input | 1 | 1 selects integer-only division and holds the modulator cleared |
| div_value | output | INT_W+1 (8) | Divide value for the current feedback cycle |
| div_valid | output | 1 | High once div_value carries a computed value |

## Verification
Several behaviours are checked on every cycle by assertions:

- the strobe stays high once it has risen;
- integer-only mode passes the integer word through;
- fractional outputs stay inside the -1 to +2 window;
- the accumulators and the delayed carry are empty after any integer-only edge.

Some properties need a whole sequence of outputs, and only the directed scenarios can show them:

- the exact long-run mean, including the half-step offset and its bound for each modulator order;
- the +2 step that an all-ones fraction produces;
- the value that appears on leaving integer-only mode.

// File: rtl/fnmod_pkg.sv
package fnmod_pkg;

   // Signed correction added to the integer word; range -1 .. +2.
   typedef logic signed [2:0] offset_t;

   localparam int MAX_ORDER = 2;

   // Widen a single carry bit into a signed correction term.
   function automatic offset_t carry_term(input logic c);
      return $signed({2'b00, c});
   endfunction

endpackage

// File: rtl/fnmod_acc_stage.sv
module fnmod_acc_stage #(
   parameter int ACC_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [ACC_W-1:0] inc,
   output logic [ACC_W-1:0] sum,
   output logic             carry
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   wide;

   always_comb begin
      wide = {1'b0, acc_q} + {1'b0, inc};
   end

   assign sum   = wide[ACC_W-1:0];
   assign carry = wide[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else begin
         acc_q <= sum;
      end
   end

   // R6: an integer-only edge leaves this stage empty
   a_r6_stage_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0));

endmodule

// File: rtl/fnmod_shaper.sv
module fnmod_shaper
   import fnmod_pkg::*;
#(
   parameter int ORDER = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [ORDER-1:0] carries,
   output offset_t          offset
);

   generate
      if (ORDER == 1) begin : g_first
         assign offset = carry_term(carries[0]);
      end else begin : g_second
         logic c_prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_prev_q <= 1'b0;
            end else if (clear) begin
               c_prev_q <= 1'b0;
            end else begin
               c_prev_q <= carries[1];
            end
         end

         // First stage carry plus the first difference of the second carry.
         assign offset = carry_term(carries[0]) + carry_term(carries[1])
                       - carry_term(c_prev_q);

         // R6: the delayed carry is empty after an integer-only edge
         a_r6_diff_empty: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> !c_prev_q);
      end
   endgenerate

endmodule

// File: rtl/frac_div_modulator.sv
module frac_div_modulator
   import fnmod_pkg::*;
#(
   parameter int INT_W  = 7,
   parameter int FRAC_W = 18,
   parameter int ORDER  = 2,
   localparam int OUT_W = INT_W + 1,
   localparam int ACC_W = FRAC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  int_word,
   input  logic [FRAC_W-1:0] frac_word,
   input  logic              int_only,
   output logic [OUT_W-1:0]  div_value,
   output logic              div_valid
);

   // R9: parameter legality
   generate
      if (INT_W < 2) begin : g_bad_int
         $error("frac_div_modulator: INT_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("frac_div_modulator: FRAC_W must be at least 1");
      end
      if (ORDER < 1 || ORDER > MAX_ORDER) begin : g_bad_order
         $error("frac_div_modulator: ORDER must be 1 or 2");
      end
   endgenerate

   // Accumulator chain; the forced low bit supplies the half-step offset.
   logic [ACC_W-1:0] stage_in [ORDER+1];
   logic [ORDER-1:0] stage_carry;

   assign stage_in[0] = {frac_word, 1'b1};

   generate
      for (genvar k = 0; k < ORDER; k++) begin : g_stage
         fnmod_acc_stage #(.ACC_W(ACC_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (int_only),
            .inc   (stage_in[k]),
            .sum   (stage_in[k+1]),
            .carry (stage_carry[k])
         );
      end
   endgenerate

   offset_t corr;

   fnmod_shaper #(.ORDER(ORDER)) u_shaper (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (int_only),
      .carries (stage_carry),
      .offset  (corr)
   );

   logic signed [OUT_W:0] frac_sum;
   logic [OUT_W-1:0]      div_next;

   always_comb begin
      frac_sum = $signed({2'b00, int_word}) + (OUT_W+1)'(corr);
      if (int_only) begin
         div_next = {1'b0, int_word};
      end else begin
         div_next = frac_sum[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_value <= '0;
         div_valid <= 1'b0;
      end else begin
         div_value <= div_next;
         div_valid <= 1'b1;
      end
   end

   // R2: the strobe never drops outside reset
   a_r2_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      div_valid |=> div_valid);

   // R3: integer-only edges pass the integer word straight through
   a_r3_int_pass: assert property (@(posedge clk) disable iff (!rst_n)
      int_only |=> (div_value == OUT_W'($past(int_word))));

   // R4: fractional values stay inside the correction window
   generate
      if (ORDER == 2) begin : g_range_chk
         a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
            (div_valid && !$past(int_only) && ($past(int_word) != '0)) |->
               ((div_value + OUT_W'(1)) >= OUT_W'($past(int_word)) &&
                div_value <= (OUT_W'($past(int_word)) + OUT_W'(2))));
      end
   endgenerate

endmodule

// File: tb/sim_frac_div_modulator.sv
module sim_frac_div_modulator;

   localparam int SF_W = 8;
   localparam int SPAN = 1 << (SF_W + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;

   // u0: default widths, two-stage
   logic [6:0]  i0 = '0;
   logic [17:0] f0 = '0;
   logic        m0 = 1'b0;
   logic [7:0]  d0;
   logic        v0;

   frac_div_modulator u0 (
      .clk(clk), .rst_n(rst_n), .int_word(i0), .frac_word(f0),
      .int_only(m0), .div_value(d0), .div_valid(v0));

   // u1: narrow fraction, two-stage; u2: narrow fraction, one stage
   logic [6:0]      i1 = '0;
   logic [SF_W-1:0] f1 = '0;
   logic [7:0]      d1, d2;
   logic            v1, v2;

   frac_div_modulator #(.FRAC_W(SF_W), .ORDER(2)) u1 (
      .clk(clk), .rst_n(rst_n), .int_word(i1), .frac_word(f1),
      .int_only(1'b0), .div_value(d1), .div_valid(v1));

   frac_div_modulator #(.FRAC_W(SF_W), .ORDER(1)) u2 (
      .clk(clk), .rst_n(rst_n), .int_word(i1), .frac_word(f1),
      .int_only(1'b0), .div_value(d2), .div_valid(v2));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0;
      i0 = 7'd20; f0 = 18'd5; m0 = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(d0 == 8'd0, "R1 value", int'(d0), 0);
      chk(v0 == 1'b0, "R1 valid", int'(v0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(v0 == 1'b1, "R2 valid rise", int'(v0), 1);
      chk(d0 == 8'd20, "R6 first after reset", int'(d0), 20);
      repeat (5) @(negedge clk);
      chk(v0 == 1'b1, "R2 valid held", int'(v0), 1);
   endtask

   task automatic t_int_mode();
      m0 = 1'b1; i0 = 7'd33; f0 = 18'h2AAAA;
      @(negedge clk);
      chk(d0 == 8'd33, "R3 int pass", int'(d0), 33);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(d0 == 8'd33, "R3 int steady", int'(d0), 33);
      end
      i0 = 7'd127;
      @(negedge clk);
      chk(d0 == 8'd127, "R8 new int word", int'(d0), 127);
   endtask

   task automatic t_max_fraction();
      m0 = 1'b1; i0 = 7'd40;
      @(negedge clk);
      m0 = 1'b0; f0 = '1;
      @(negedge clk);
      chk(d0 == 8'd40, "R6 first after int mode", int'(d0), 40);
      @(negedge clk);
      chk(d0 == 8'd42, "R7 max fraction step", int'(d0), 42);
   endtask

   task automatic t_range();
      int outside = 0;
      m0 = 1'b0; i0 = 7'd50; f0 = 18'd12345;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (d0 < 8'd49 || d0 > 8'd52) outside++;
      end
      chk(outside == 0, "R4 window", outside, 0);
   endtask

   task automatic t_average(input int m, input int iw);
      int s1 = 0;
      int s2 = 0;
      int base;
      i1 = 7'(iw); f1 = SF_W'(m);
      do_reset();
      for (int k = 0; k < SPAN; k++) begin
         @(negedge clk);
         s1 += int'(d1);
         s2 += int'(d2);
      end
      base = iw * SPAN + 2 * m + 1;
      chk(s2 == base, "R5 mean one stage", s2, base);
      chk(s1 == base || s1 == base + 1, "R5 mean two stage", s1, base);
   endtask

   initial begin
      #1000000;
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_int_mode();
      t_max_fraction();
      t_range();
      t_average(0, 9);
      t_average(100, 64);
      t_average(255, 3);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule